// File: doc/BRIEF.md
# Self-Synchronizing Payload Scrambler (x^43 + 1)

This block scrambles or descrambles a cell payload stream with the self-synchronizing polynomial x^43 + 1, handling a whole word (8 or 16 bits) per clock. The serial recurrence is unrolled once for each bit of the word. The transmit side runs it as a multiplicative scrambler: each scrambled bit is fed back into a 43-bit history. The receive side runs the matching feed-forward descrambler. It keeps the history of received bits, so after any corruption it locks back onto the data on its own.

A per-word valid strobe marks payload. Only payload words advance the history. Any other word leaves the history untouched and goes to the output unchanged. A mode input chooses scrambling or descrambling for each word. Outputs are registered, with the output valid aligned to the output data. Cell delineation, header handling and serialization live elsewhere.

Top module: `payload_scrambler43`

## Requirements
- R1: After reset the output valid and output data are 0, and all 43 history bits are 0. As a result, the first 43 payload bits after reset leave the scrambler unchanged.
- R2: In scramble mode each word is processed bit by bit, most significant bit first. Each bit is XORed with the oldest history bit (position 42). The history then shifts up by one place, and the new bit enters at position 0.
- R3: The scrambled bit that is output is the XOR result, and that same XOR result is the bit loaded into history position 0.
- R4: In descramble mode each output bit is the received bit XOR history position 42. The received bit, not the output bit, is shifted into position 0.
- R5: A word with in_valid low leaves the history unchanged, and its out_data equals its in_data.
- R6: out_data and out_valid appear one clock after the input word. out_valid equals the in_valid of that word.
- R7: Scrambling a payload stream and then descrambling it with a second instance, both started from reset, returns the original data.
- R8: After corrupted input, the descrambler output again equals the original data once 43 payload bits have been received past the last corrupted word, with no control action.
- R9: With parameter W = 16 the block gives the same output and the same history as 16 consecutive serial steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| descr_mode | input | 1 | 0 = scramble, 1 = descramble (sampled per word) |
| in_valid | input | 1 | Word carries payload and advances the history |
| in_data | input | W | Input word, bit W-1 first in serial order |
| out_valid | output | 1 | in_valid delayed by one clock |
| out_data | output | W | Processed word, or pass-through of a non-payload word |

## Verification
The hardest situation to reach is a descrambler whose history disagrees with the transmitter's, followed by recovery. Recovery must happen exactly at the 43-bit boundary, and idle words in between must not count toward it. The bench sends the scrambler output into a second, descrambling instance and flips single bits on that link at random payload words. Random idle gaps are mixed in, so the recovery distance is measured in payload bits and not in clocks. Words still inside the echo window are held out of the round-trip comparison, and every word after the window must match the original data.

// File: rtl/scr43_pkg.sv
`timescale 1ns/1ps
package scr43_pkg;
  localparam int SR_LEN = 43;
  typedef logic [SR_LEN-1:0] sr_t;
  typedef enum logic {
    MODE_SCRAMBLE   = 1'b0,
    MODE_DESCRAMBLE = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/scr43_rst_sync.sv
`timescale 1ns/1ps
module scr43_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/scr43_bitstep.sv
`timescale 1ns/1ps
// One serial step of the recurrence: combine a bit with the oldest history
// bit and shift the appropriate bit into the newest position.
module scr43_bitstep
  import scr43_pkg::*;
(
  input  sr_t       st_i,
  input  logic      bit_i,
  input  scr_mode_e mode_i,
  output sr_t       st_o,
  output logic      bit_o
);
  logic fb;

  always_comb begin
    bit_o = bit_i ^ st_i[SR_LEN-1];
    fb    = (mode_i == MODE_DESCRAMBLE) ? bit_i : bit_o;
    st_o  = {st_i[SR_LEN-2:0], fb};
  end
endmodule

// File: rtl/scr43_unroll.sv
`timescale 1ns/1ps
// W serial steps chained combinationally; step j consumes bit W-1-j.
module scr43_unroll
  import scr43_pkg::*;
#(
  parameter int W = 8
) (
  input  sr_t          st_i,
  input  logic [W-1:0] word_i,
  input  scr_mode_e    mode_i,
  output sr_t          st_o,
  output logic [W-1:0] word_o
);
  sr_t chain [0:W];

  assign chain[0] = st_i;

  for (genvar j = 0; j < W; j++) begin : g_step
    scr43_bitstep u_step (
      .st_i   (chain[j]),
      .bit_i  (word_i[W-1-j]),
      .mode_i (mode_i),
      .st_o   (chain[j+1]),
      .bit_o  (word_o[W-1-j])
    );
  end

  assign st_o = chain[W];
endmodule

// File: rtl/scr43_state.sv
`timescale 1ns/1ps
module scr43_state
  import scr43_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  sr_t  st_nxt_i,
  output sr_t  st_o
);
  sr_t st_q;
  sr_t st_d;

  always_comb st_d = adv_i ? st_nxt_i : st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/scr43_outreg.sv
`timescale 1ns/1ps
module scr43_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] proc_i,
  input  logic [W-1:0] raw_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;
  logic [W-1:0] data_d;

  always_comb data_d = valid_i ? proc_i : raw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_i;
      data_q  <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/payload_scrambler43.sv
`timescale 1ns/1ps
module payload_scrambler43
  import scr43_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         descr_mode,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int LOW_TOP = SR_LEN - 1 - W;

  logic         rst_sync_n;
  sr_t          st_q;
  sr_t          st_nxt;
  logic [W-1:0] word_proc;
  scr_mode_e    mode;

  assign mode = descr_mode ? MODE_DESCRAMBLE : MODE_SCRAMBLE;

  scr43_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scr43_unroll #(.W(W)) u_unroll (
    .st_i   (st_q),
    .word_i (in_data),
    .mode_i (mode),
    .st_o   (st_nxt),
    .word_o (word_proc)
  );

  scr43_state u_state (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv_i    (in_valid),
    .st_nxt_i (st_nxt),
    .st_o     (st_q)
  );

  scr43_outreg #(.W(W)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .valid_i (in_valid),
    .proc_i  (word_proc),
    .raw_i   (in_data),
    .valid_o (out_valid),
    .data_o  (out_data)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R6
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R6
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (out_data == $past(in_data))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(st_q)); // R5
  AST_SCR_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !descr_mode) |=> (st_q[W-1:0] == out_data)); // R3
  AST_DSC_FEEDFWD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && descr_mode) |=> (st_q[W-1:0] == $past(in_data))); // R4
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (st_q[SR_LEN-1:W] == $past(st_q[LOW_TOP:0]))); // R2
endmodule

// File: tb/payload_scrambler43_bench.sv
`timescale 1ns/1ps
module payload_scrambler43_bench;
  logic clk;
  logic rst_n;

  logic       tx_v, tx_ov;
  logic [7:0] tx_d, tx_od;
  logic [7:0] err;
  logic [7:0] rx_in, rx_od;
  logic       rx_ov;
  logic        w_v, w_m, w_ov;
  logic [15:0] w_d, w_od;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign rx_in = tx_od ^ err;

  payload_scrambler43 #(.W(8)) u_payload_scrambler43 (
    .clk(clk), .rst_n(rst_n), .descr_mode(1'b0), .in_valid(tx_v),
    .in_data(tx_d), .out_valid(tx_ov), .out_data(tx_od));

  payload_scrambler43 #(.W(8)) u_payload_scrambler43_rx (
    .clk(clk), .rst_n(rst_n), .descr_mode(1'b1), .in_valid(tx_ov),
    .in_data(rx_in), .out_valid(rx_ov), .out_data(rx_od));

  payload_scrambler43 #(.W(16)) u_payload_scrambler43_w16 (
    .clk(clk), .rst_n(rst_n), .descr_mode(w_m), .in_valid(w_v),
    .in_data(w_d), .out_valid(w_ov), .out_data(w_od));

  // bit-serial reference, most significant bit first
  function automatic logic [15:0] ref_word(input logic [42:0] st_in,
      input logic [15:0] d, input int w, input bit descr,
      output logic [42:0] st_out);
    logic [42:0] s;
    logic [15:0] y;
    logic        b;
    s = st_in;
    y = '0;
    for (int i = w - 1; i >= 0; i--) begin
      b    = d[i] ^ s[42];
      y[i] = b;
      s    = {s[41:0], (descr ? d[i] : b)};
    end
    st_out = s;
    return y;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [42:0] st_tx, st_rx, st_w;
  logic        etx_v, erx_v, ew_v;
  logic [7:0]  etx_d, erx_d, orig_prev, rt_d;
  logic [15:0] ew_d;
  bit          rt_ok, err_seen;
  int          since_err;

  task automatic model_reset();
    st_tx = '0; st_rx = '0; st_w = '0;
    etx_v = 0; erx_v = 0; ew_v = 0;
    etx_d = '0; erx_d = '0; ew_d = '0;
    orig_prev = '0; rt_d = '0; rt_ok = 0; err_seen = 0;
    since_err = 1000;
  endtask

  task automatic step(input bit v, input logic [7:0] d, input logic [7:0] e,
                      input bit v16, input bit m16, input logic [15:0] d16);
    logic [7:0] rin;
    @(negedge clk);
    chk("R6 tx valid", {15'd0, tx_ov}, {15'd0, etx_v});
    chk(etx_v ? "R2,R3 scramble word" : "R5 tx idle pass", {8'd0, tx_od}, {8'd0, etx_d});
    chk("R6 rx valid", {15'd0, rx_ov}, {15'd0, erx_v});
    chk(erx_v ? "R4 descramble word" : "R5 rx idle pass", {8'd0, rx_od}, {8'd0, erx_d});
    if (erx_v && rt_ok)
      chk(err_seen ? "R8 resync round trip" : "R7 round trip", {8'd0, rx_od}, {8'd0, rt_d});
    chk("R9 w16 valid", {15'd0, w_ov}, {15'd0, ew_v});
    chk(ew_v ? "R9 w16 word" : "R5 w16 idle pass", w_od, ew_d);

    // receive side sees the transmit output now on its input
    rin   = etx_d ^ e;
    erx_v = etx_v;
    if (etx_v) begin
      erx_d = ref_word(st_rx, {8'd0, rin}, 8, 1'b1, st_rx);
      rt_d  = orig_prev;
      if (e != 0) begin
        since_err = 0; rt_ok = 0; err_seen = 1;
      end else begin
        rt_ok = (since_err >= 43);
        if (since_err < 1000) since_err += 8;
      end
    end else begin
      erx_d = rin;
    end
    etx_v     = v;
    etx_d     = v ? ref_word(st_tx, {8'd0, d}, 8, 1'b0, st_tx) : d;
    orig_prev = d;
    ew_v      = v16;
    ew_d      = v16 ? ref_word(st_w, d16, 16, m16, st_w) : d16;

    tx_v = v; tx_d = d; err = e;
    w_v = v16; w_m = m16; w_d = d16;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    tx_v = 0; tx_d = '0; err = '0; w_v = 0; w_m = 0; w_d = '0;
    model_reset();
    repeat (4) @(negedge clk);
    // R1: reset values at the ports
    chk("R1 reset valid", {15'd0, tx_ov}, 16'd0);
    chk("R1 reset data", {8'd0, tx_od}, 16'd0);
    chk("R1 reset w16 data", w_od, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: zero history means the first payload word passes unchanged
    step(1, 8'hA5, 8'h00, 1, 0, 16'h1234);
    @(posedge clk); #1;
    chk("R1 first word unchanged", {8'd0, tx_od}, 16'h00A5);
    chk("R1 first w16 word unchanged", w_od, 16'h1234);

    // directed: all ones, zeros, idle gaps, mode change on the wide lane
    for (int k = 0; k < 8; k++) step(1, 8'hFF, 8'h00, 1, 0, 16'hFFFF);
    for (int k = 0; k < 3; k++) step(0, 8'h3C, 8'h00, 0, 1, 16'hC33C);
    for (int k = 0; k < 8; k++) step(1, 8'h00, 8'h00, 1, 1, 16'h0000);
    step(0, 8'h5A, 8'h00, 0, 0, 16'hBEEF);
    for (int k = 0; k < 8; k++) step(1, 8'h81, 8'h00, 1, 0, 16'h8001);
    // directed R8: one flipped bit followed by clean payload
    step(1, 8'h11, 8'h00, 1, 0, 16'h0);
    step(1, 8'h22, 8'h80, 1, 0, 16'h0);
    for (int k = 0; k < 10; k++) step(1, 8'(k * 7), 8'h00, 0, 0, 16'h0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit          v, v16, m16;
      logic [7:0]  d, e;
      logic [15:0] d16;
      v   = ($urandom % 4) != 0;
      d   = 8'($urandom);
      e   = (($urandom % 60) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      v16 = ($urandom % 3) != 0;
      m16 = ($urandom % 2) == 1;
      d16 = 16'($urandom);
      step(v, d, e, v16, m16, d16);
    end
    for (int k = 0; k < 3; k++) step(0, 8'h00, 8'h00, 0, 0, 16'h0);
    finish_run();
  end
endmodule